// File: doc/BRIEF.md
# Shared-Bus 32x8 Static RAM

This block is a small static memory of 32 words of 8 bits. It is meant to sit on a processor bus whose data lines carry both read and write traffic. A 5-bit address picks the word. Three active-low controls set what the block does: a select, a read (output) strobe and a write strobe. The shared data lines are split into a data-in port, a data-out port and an output-enable flag, so a tristate driver can be placed at the chip boundary. Several copies can share one bus as long as each has its own select line.

The array is fully decoded. Reads are combinational: the word at the current address appears on data-out while output-enable is high. The host supplies no precharge phase and no read clock. The system clock is used only to sample the write strobe. A word is committed on the clock edge where the write strobe is first seen high after being seen low, provided the write condition held before that edge. The read strobe has priority over the write strobe: while it is low, the block reads and nothing is stored. The memory contents are not reset.

Top module: `bus_sram32x8`

## Requirements
- R1: With select low and read strobe low, dout_en is 1 and dout equals the word stored at addr, whatever the level of the write strobe.
- R2: A read is combinational. A change of addr while the read condition holds changes dout in the same cycle, with no strobe edge and no clock edge needed.
- R3: A write needs two consecutive clock edges. At the first, select is low, read strobe is high and write strobe is low. At the second, select is low, read strobe is high and write strobe is high. At the second edge, din is stored at addr.
- R4: While select is low, read strobe is high and write strobe is low, dout_en is 0 and dout is 0.
- R5: Any write strobe activity while the read strobe is low leaves the memory unchanged.
- R6: With select high, dout_en is 0, dout is 0, and no write strobe activity changes the memory.
- R7: With select low and both strobes high, dout_en is 0 and dout is 0. Holding this standby state for many cycles changes nothing stored.
- R8: Whenever dout_en is 0, dout is 0.
- R9: A synchronous reset on rst_n (active low) clears the write history. A write strobe that is high at the first edge after reset stores nothing, even if it was low while reset was held.
- R10: All 32 addresses are independent. Writing one word leaves the other 31 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the write strobe |
| rst_n | input | 1 | Synchronous active-low reset of the write history (not of the array) |
| addr | input | 5 | Word address |
| sel_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read / output strobe; overrides the write strobe |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 8 | Write data from the shared bus |
| dout | output | 8 | Read data toward the shared bus; zero when not driving |
| dout_en | output | 1 | High when the block should drive the bus |

## Verification
The assertions assume that the strobes and the select are sampled only at clock edges and settle between edges. They also assume that the host never relies on a word it has not written. The stimulus changes every input half a period away from the active edge and keeps din stable across both edges of a write. It also writes all 32 words before any data comparison. The checks cover the case where a read and a write overlap, the case where the write strobe rises while the block is deselected, and the case where reset falls in the middle of a write.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_READ    = 2'd1,
    MODE_WRITE   = 2'd2,
    MODE_STANDBY = 2'd3
  } bus_mode_e;

  // Read strobe wins over write strobe; select gates everything.
  function automatic bus_mode_e decode_mode(input logic sel_n,
                                            input logic rd_n,
                                            input logic wr_n);
    bus_mode_e m;
    if (sel_n)       m = MODE_OFF;
    else if (!rd_n)  m = MODE_READ;
    else if (!wr_n)  m = MODE_WRITE;
    else             m = MODE_STANDBY;
    return m;
  endfunction

  // Bit offset of a word inside the flattened storage vector.
  function automatic int word_base(input int index, input int width);
    return index * width;
  endfunction

endpackage

// File: rtl/bsram_mode_decode.sv
module bsram_mode_decode
  import bsram_pkg::*;
(
  input  logic      sel_n,
  input  logic      rd_n,
  input  logic      wr_n,
  output bus_mode_e mode,
  output logic      read_cond,
  output logic      write_cond,
  output logic      standby_cond
);
  always_comb begin
    mode         = decode_mode(sel_n, rd_n, wr_n);
    read_cond    = (mode == MODE_READ);
    write_cond   = (mode == MODE_WRITE);
    standby_cond = (mode == MODE_STANDBY);
  end
endmodule

// File: rtl/bsram_write_sync.sv
module bsram_write_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic write_cond,
  input  logic standby_cond,
  output logic armed,
  output logic commit
);
  // armed: write condition was seen at the previous edge
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= write_cond;
  end

  // strobe released while still selected and not reading
  assign commit = rst_n && armed && standby_cond;
endmodule

// File: rtl/bsram_array.sv
module bsram_array
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH*DATA_W-1:0] flat;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    logic [DATA_W-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (we && (waddr == ADDR_W'(gi))) cell_q <= wdata;
    end
    assign flat[word_base(gi, DATA_W) +: DATA_W] = cell_q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (raddr == ADDR_W'(i)) rdata = flat[word_base(i, DATA_W) +: DATA_W];
    end
  end
endmodule

// File: rtl/bus_sram32x8.sv
module bus_sram32x8
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  bus_mode_e         mode_w;
  logic              read_w, write_w, standby_w;
  logic              armed_w, commit_w;
  logic [DATA_W-1:0] word_w;

  bsram_mode_decode dec_i (
    .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
    .mode(mode_w), .read_cond(read_w),
    .write_cond(write_w), .standby_cond(standby_w)
  );

  bsram_write_sync wsync_i (
    .clk(clk), .rst_n(rst_n),
    .write_cond(write_w), .standby_cond(standby_w),
    .armed(armed_w), .commit(commit_w)
  );

  bsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) arr_i (
    .clk(clk), .we(commit_w), .waddr(addr), .wdata(din),
    .raddr(addr), .rdata(word_w)
  );

  assign dout_en = read_w;
  assign dout    = read_w ? word_w : '0;
endmodule

// File: rtl/bsram_checker.sv
module bsram_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              armed,
  input logic              commit
);
  p_read_drives_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !rd_n) |-> dout_en);

  p_commit_after_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(!wr_n) && wr_n));

  p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && rd_n && !wr_n) |-> !dout_en);

  p_read_blocks_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !commit);

  p_deselect_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> (!commit && !dout_en));

  p_standby_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && rd_n && wr_n) |-> !dout_en);

  p_zero_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));

  p_reset_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !armed);
endmodule

bind bus_sram32x8 bsram_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
  .dout(dout), .dout_en(dout_en), .armed(armed_w), .commit(commit_w)
);

// File: tb/bus_sram32x8_tb_top.sv
`timescale 1ns/1ps
module bus_sram32x8_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic       sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_en;

  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [7:0] ref_mem [32];
  bit         known   [32];
  bit         ref_armed = 0;

  always #2 clk = ~clk;  // 250 MHz

  bus_sram32x8 dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .rd_n(rd_n),
    .wr_n(wr_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'((a * 37 + 5 + k * 91) & 255);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, compare outputs, then advance the model at posedge.
  task automatic step(input logic s, input logic r, input logic w,
                      input logic [4:0] a, input logic [7:0] d, input string tag);
    bit exp_en;
    sel_n = s; rd_n = r; wr_n = w; addr = a; din = d;
    #1;
    exp_en = !s && !r;
    check({tag, " dout_en"}, int'(dout_en), int'(exp_en));
    if (!exp_en) check({tag, " dout idle"}, int'(dout), 0);
    else if (known[a]) check({tag, " dout data"}, int'(dout), int'(ref_mem[a]));
    @(posedge clk);
    if (!rst_n) ref_armed = 0;
    else begin
      if (ref_armed && !s && r && w) begin
        ref_mem[a] = d;
        known[a]   = 1;
      end
      ref_armed = !s && r && !w;
    end
    @(negedge clk);
  endtask

  task automatic write_word(input logic [4:0] a, input logic [7:0] d, input string tag);
    step(1'b0, 1'b1, 1'b0, a, d, tag);
    step(1'b0, 1'b1, 1'b1, a, d, tag);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin ref_mem[i] = '0; known[i] = 0; end
    @(negedge clk);
    // reset state
    step(1'b1, 1'b1, 1'b1, 5'd0, 8'h00, "R6 reset deselected");
    step(1'b1, 1'b1, 1'b1, 5'd0, 8'h00, "R8 reset idle");
    rst_n = 1'b1;
    @(negedge clk);

    // R10 / R3: fill every location; R4 checked during each write
    for (int a = 0; a < 32; a++) write_word(5'(a), pat(a, 0), "R3 R4 fill");
    // R1 / R10: read all back, write strobe high then low
    for (int a = 0; a < 32; a++) step(1'b0, 1'b0, 1'b1, 5'(a), 8'h00, "R1 R10 read");
    for (int a = 31; a >= 0; a--) step(1'b0, 1'b0, 1'b0, 5'(a), 8'h00, "R1 read wr low");

    // R2: address moves mid-cycle with read held
    sel_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      addr = 5'(a * 7 + 1);
      #0.5;
      check("R2 comb read", int'(dout), int'(ref_mem[5'(a * 7 + 1)]));
    end
    @(negedge clk);

    // R5: write strobe activity under read strobe
    step(1'b0, 1'b0, 1'b0, 5'd9, 8'hA5, "R5 rd+wr low");
    step(1'b0, 1'b0, 1'b1, 5'd9, 8'hA5, "R5 rise under read");
    step(1'b0, 1'b0, 1'b0, 5'd9, 8'hA5, "R5 rd+wr low again");
    step(1'b0, 1'b1, 1'b1, 5'd9, 8'hA5, "R5 release both");
    step(1'b0, 1'b0, 1'b1, 5'd9, 8'h00, "R5 unchanged");

    // R6: pulse while deselected
    step(1'b1, 1'b1, 1'b0, 5'd12, 8'h3C, "R6 deselect wr low");
    step(1'b1, 1'b1, 1'b1, 5'd12, 8'h3C, "R6 deselect wr rise");
    step(1'b0, 1'b1, 1'b0, 5'd12, 8'h3C, "R6 select mid pulse");
    step(1'b1, 1'b1, 1'b1, 5'd12, 8'h3C, "R6 deselect at rise");
    step(1'b0, 1'b0, 1'b1, 5'd12, 8'h00, "R6 unchanged");

    // R7: long standby
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b1, 5'(i), 8'hFF, "R7 standby");
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b1, 5'(i), 8'h00, "R7 unchanged");

    // R9: reset lands mid-write
    step(1'b0, 1'b1, 1'b0, 5'd20, 8'h77, "R9 arm");
    rst_n = 1'b0;
    step(1'b0, 1'b1, 1'b0, 5'd20, 8'h77, "R9 in reset");
    rst_n = 1'b1;
    step(1'b0, 1'b1, 1'b1, 5'd20, 8'h77, "R9 rise after reset");
    step(1'b0, 1'b0, 1'b1, 5'd20, 8'h00, "R9 unchanged");

    // R3 / R10: overwrite a few, verify neighbours
    for (int a = 0; a < 32; a += 5) write_word(5'(a), pat(a, 1), "R3 overwrite");
    for (int a = 0; a < 32; a++) step(1'b0, 1'b0, 1'b1, 5'(a), 8'h00, "R10 neighbours");
    // R8: idle after everything
    step(1'b1, 1'b0, 1'b0, 5'd3, 8'h00, "R8 deselected read");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule